// File: doc/BRIEF.md
# Serial ADC Conversion Frame Reader

This block is the host-side controller for a three-wire serial sigma-delta converter: one chip-select output, one serial clock output and one data input. A one-cycle `start` request pulls chip select low. The reader then polls the data line without clocking it. The converter holds that line high while a conversion is running and drops it low once a result is ready.

When the line goes low, the reader produces exactly 32 serial clock pulses. The serial clock is derived from the system clock by a parameterised half-period divider and rests low. The reader samples one bit on every rising serial clock edge, most significant bit first. It then raises chip select and splits the captured word into a status nibble, a 24-bit result and four sub-LSB bits. These fields appear together with a one-cycle valid strobe.

The sign and extended-range flags are combined into over-range and under-range indications. If the data line never goes low, a timeout ends the request and sets an error flag.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and in the cycle after it, `cs_n` is high, `sck` is low, and `valid`, `busy` and `timeout` are low.
- R2: A `start` pulse in idle drives `cs_n` low. While `sdo` stays high, no serial clock edge is produced.
- R3: Serial clock high and low phases each last `SCK_HALF` system cycles. The clock is low whenever `cs_n` is high, and each frame has exactly 32 rising edges.
- R4: One bit is sampled per rising serial clock edge, first bit as frame bit 31. The frame layout is: bit 31 end-of-conversion (low), bit 30 channel (0 or 1), bit 29 sign, bit 28 extended range, bits 27..4 result, bits 3..0 sub-LSBs.
- R5: `valid` is a one-cycle pulse. It rises 64*`SCK_HALF` system clock edges after the first edge at which the reader sees `sdo` low, and `cs_n` is high in the same cycle.
- R6: `over_range` is high when sign=1 and ext=1. `under_range` is high when sign=0 and ext=1. Both are low when ext=0.
- R7: If `sdo` stays high for `TIMEOUT_CYCLES` cycles after chip select falls, `cs_n` rises and `timeout` goes high with no `valid`. The next `start` clears `timeout`.
- R8: A `start` pulse while the reader is busy is ignored. The frame in progress completes unchanged.
- R9: The decoded outputs hold their values between `valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to read one conversion |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, rests low |
| busy | output | 1 | A read is in progress |
| valid | output | 1 | One-cycle strobe for new decoded fields |
| result | output | 24 | Conversion result |
| sub_lsb | output | 4 | Bits below the result LSB |
| channel | output | 1 | Channel of the conversion |
| sign | output | 1 | Sign flag |
| ext_range | output | 1 | Extended-range flag |
| over_range | output | 1 | Input above the reference |
| under_range | output | 1 | Input below zero |
| timeout | output | 1 | End-of-conversion wait expired |

## Verification
Chip select falls on the first clock edge after `start`. The timeout flag rises `TIMEOUT_CYCLES` edges after that, so the bench counts 1+`TIMEOUT_CYCLES` cycles from its own `start` drive. The valid strobe and the decoded fields arrive 64*`SCK_HALF` edges after the first edge that sees `sdo` low. Because the bench model releases `sdo` midway between edges, it expects `valid` exactly 1+64*`SCK_HALF` cycle counts after that release. It samples every output at the falling system clock edge, then checks the next sample to confirm that `valid` lasted one cycle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int FRAME_W = 32;
    localparam int RES_W   = 24;
    localparam int SUB_W   = 4;
    localparam int BCNT_W  = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_e;

    // Field order follows the order bits leave the converter
    typedef struct packed {
        logic             eoc;
        logic             chan;
        logic             sign;
        logic             ext;
        logic [RES_W-1:0] data;
        logic [SUB_W-1:0] sub;
    } frame_t;

    typedef struct packed {
        logic over;
        logic under;
    } range_t;

    function automatic range_t classify(input frame_t f);
        range_t r;
        r.over  = f.ext &  f.sign;
        r.under = f.ext & ~f.sign;
        return r;
    endfunction

endpackage

// File: rtl/adc_rd_sck_gen.sv
module adc_rd_sck_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          sck_q;
    logic          tick;

    assign tick   = run_i && (cnt == CW'(HALF - 1));
    assign rise_o = tick && !sck_q;
    assign fall_o = tick &&  sck_q;
    assign sck_o  = sck_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt   <= '0;
            sck_q <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         din_i,
    output logic [W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            word_o <= '0;
        end else if (shift_i) begin
            word_o <= {word_o[W-2:0], din_i};
        end
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int SCK_HALF       = 4,
    parameter int TIMEOUT_CYCLES = 1000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sdo,
    output logic             cs_n,
    output logic             sck,
    output logic             busy,
    output logic             valid,
    output logic [RES_W-1:0] result,
    output logic [SUB_W-1:0] sub_lsb,
    output logic             channel,
    output logic             sign,
    output logic             ext_range,
    output logic             over_range,
    output logic             under_range,
    output logic             timeout
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

    rd_state_e          state;
    logic [TW-1:0]      wait_cnt;
    logic [BCNT_W-1:0]  bit_cnt;
    logic               sck_rise;
    logic               sck_fall;
    logic [FRAME_W-1:0] word;
    frame_t             fr;
    range_t             rng;

    adc_rd_sck_gen #(.HALF(SCK_HALF)) u_sck (
        .clk    (clk),
        .rst    (rst),
        .run_i  (state == ST_SHIFT),
        .sck_o  (sck),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    adc_rd_shifter #(.W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (state == ST_WAIT),
        .shift_i (sck_rise),
        .din_i   (sdo),
        .word_o  (word)
    );

    assign fr   = frame_t'(word);
    assign rng  = classify(fr);
    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cs_n        <= 1'b1;
            valid       <= 1'b0;
            timeout     <= 1'b0;
            wait_cnt    <= '0;
            bit_cnt     <= '0;
            result      <= '0;
            sub_lsb     <= '0;
            channel     <= 1'b0;
            sign        <= 1'b0;
            ext_range   <= 1'b0;
            over_range  <= 1'b0;
            under_range <= 1'b0;
        end else begin
            valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_WAIT;
                        cs_n     <= 1'b0;
                        wait_cnt <= '0;
                        timeout  <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (!sdo) begin
                        state   <= ST_SHIFT;
                        bit_cnt <= '0;
                    end else if (wait_cnt == TW'(TIMEOUT_CYCLES - 1)) begin
                        state   <= ST_IDLE;
                        cs_n    <= 1'b1;
                        timeout <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (sck_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (sck_fall && bit_cnt == BCNT_W'(FRAME_W)) begin
                        state       <= ST_IDLE;
                        cs_n        <= 1'b1;
                        valid       <= 1'b1;
                        result      <= fr.data;
                        sub_lsb     <= fr.sub;
                        channel     <= fr.chan;
                        sign        <= fr.sign;
                        ext_range   <= fr.ext;
                        over_range  <= rng.over;
                        under_range <= rng.under;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk
    import adc_rd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input rd_state_e        state_i,
    input logic             cs_n,
    input logic             sck,
    input logic             busy,
    input logic             valid,
    input logic [RES_W-1:0] result,
    input logic             over_range,
    input logic             under_range,
    input logic             timeout
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (cs_n && !sck && !valid && !busy && !timeout));

    assert_no_sck_polling_R2: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_WAIT) |-> !sck);

    assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_valid_cs_high_R5: assert property (@(posedge clk) disable iff (rst)
        valid |-> cs_n);

    assert_range_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(over_range && under_range));

    assert_timeout_cs_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> (cs_n && !valid));

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (start && (state_i == ST_SHIFT)) |=> (state_i != ST_WAIT));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(result) || valid);
endmodule

bind adc_frame_reader adc_frame_reader_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .state_i     (state),
    .cs_n        (cs_n),
    .sck         (sck),
    .busy        (busy),
    .valid       (valid),
    .result      (result),
    .over_range  (over_range),
    .under_range (under_range),
    .timeout     (timeout)
);

// File: tb/adc_frame_reader_tb.sv
`timescale 1ns/1ps
module adc_frame_reader_tb;
    localparam int HALF = 2;
    localparam int TMO  = 40;
    localparam int NV   = 5;
    // {frame[31:0], eoc delay[7:0]}
    localparam logic [39:0] VEC [NV] = '{
        {32'h2123456A, 8'd3},
        {32'h4FEDCBA5, 8'd10},
        {32'h3000001F, 8'd1},
        {32'h5FFFFFF3, 8'd25},
        {32'h20000000, 8'd6}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic sdo;
    logic cs_n, sck, busy, valid, channel, sign, ext_range, over_range, under_range, timeout;
    logic [23:0] result;
    logic [3:0]  sub_lsb;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rise_cnt = 0;
    logic [31:0] frame_m = 32'hFFFFFFFF;
    logic        ready_m = 1'b0;
    logic [5:0]  idx = 6'd0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge sck) rise_cnt <= rise_cnt + 1;

    // Converter model: next bit leaves on each falling serial clock edge
    always @(negedge sck or posedge cs_n) begin
        if (cs_n) idx <= 6'd0;
        else      idx <= idx + 6'd1;
    end
    assign sdo = cs_n ? 1'b1 : (!ready_m ? 1'b1 : (idx < 6'd32 ? frame_m[5'(31 - idx)] : 1'b1));

    adc_frame_reader #(.SCK_HALF(HALF), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst(rst), .start(start), .sdo(sdo), .cs_n(cs_n), .sck(sck),
        .busy(busy), .valid(valid), .result(result), .sub_lsb(sub_lsb),
        .channel(channel), .sign(sign), .ext_range(ext_range),
        .over_range(over_range), .under_range(under_range), .timeout(timeout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [31:0] f, input int dly, input bit poke);
        int t0;
        int g;
        frame_m  = f;
        ready_m  = 1'b0;
        rise_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (dly) @(negedge clk);
        chk("R2 cs_n low while polling", 32'(cs_n), 32'd0);
        chk("R2 no sck edge while polling", 32'(rise_cnt), 32'd0);
        ready_m = 1'b1;
        t0 = cyc;
        g = 0;
        do begin
            @(negedge clk);
            start = poke && (g == 30);
            g++;
        end while (!valid && g < 2000);
        start = 1'b0;
        chk("R5 valid latency", 32'(cyc - t0), 32'(1 + 64 * HALF));
        chk("R5 cs_n high with valid", 32'(cs_n), 32'd1);
        chk("R3 rising edge count", 32'(rise_cnt), 32'd32);
        chk("R4 result field", 32'(result), 32'(f[27:4]));
        chk("R4 sub_lsb field", 32'(sub_lsb), 32'(f[3:0]));
        chk("R4 channel bit", 32'(channel), 32'(f[30]));
        chk("R4 sign bit", 32'(sign), 32'(f[29]));
        chk("R4 ext bit", 32'(ext_range), 32'(f[28]));
        chk("R6 over_range", 32'(over_range), 32'(f[29] & f[28]));
        chk("R6 under_range", 32'(under_range), 32'(~f[29] & f[28]));
        @(negedge clk);
        chk("R5 valid one cycle", 32'(valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", 32'(cs_n), 32'd1);
        chk("R1 sck in reset", 32'(sck), 32'd0);
        chk("R1 valid/busy/timeout in reset", {29'd0, valid, busy, timeout}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", {30'd0, busy, cs_n}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i][39:8], int'(VEC[i][7:0]), 1'b0);
        end

        // R8: start pulse in the middle of a frame
        run_frame(32'h6ABCDEF9, 4, 1'b1);
        repeat (5) @(negedge clk);
        chk("R8 no new request after busy start", {30'd0, busy, cs_n}, 32'd1);

        // R9: outputs hold while idle
        repeat (20) @(negedge clk);
        chk("R9 result holds", 32'(result), 32'h0ABCDEF);
        chk("R9 channel holds", 32'(channel), 32'd1);

        // R7: converter never finishes
        begin
            int c0;
            int g;
            bit seen_valid;
            frame_m = 32'h2111111A;
            ready_m = 1'b0;
            rise_cnt = 0;
            seen_valid = 1'b0;
            @(negedge clk) start = 1'b1;
            c0 = cyc;
            @(negedge clk) start = 1'b0;
            g = 0;
            while (!timeout && g < 500) begin
                @(negedge clk);
                if (valid) seen_valid = 1'b1;
                g++;
            end
            chk("R7 timeout latency", 32'(cyc - c0), 32'(1 + TMO));
            chk("R7 cs_n high after timeout", 32'(cs_n), 32'd1);
            chk("R7 no valid on timeout", 32'(seen_valid), 32'd0);
            chk("R7 no sck on timeout", 32'(rise_cnt), 32'd0);
            chk("R9 result kept after timeout", 32'(result), 32'h0ABCDEF);
        end

        // R7: next request clears the flag and reads normally
        frame_m = 32'h2111111A;
        ready_m = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R7 timeout cleared by start", 32'(timeout), 32'd0);
        repeat (TMO + 5) @(negedge clk);
        run_frame(32'h2111111A, 2, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule